// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block compares two words, P and Q, and reports the decision on two lines: P greater than Q and P less than Q. When both lines are low, the words are equal. A mode input chooses the form of the comparison. It is either unsigned, or two's complement with the top bit as the sign. Two cascade inputs carry the decision of a stage that handles less-significant bits. When the local words are equal, those inputs pass through to the outputs, so stages can be chained into a comparison of any width. No logic is needed between stages. The least-significant stage ties its cascade inputs low. Only the most-significant stage of a chain should use the signed mode.

The P operand goes through a holding stage controlled by a load input. While load is high, the comparison sees the present P input directly. The stage also records P at each rising clock edge. While load is low, the comparison uses the recorded word and ignores the P input. A synchronous active-low reset clears the recorded word to zero, which models power-up clear. Apart from this storage, the block is combinational from its inputs to its outputs.

Top module: `cmp_stage`

## Requirements
- R1: With `signed_mode` = 0 and the effective P different from `q_in`, `gt_out` is 1 and `lt_out` is 0 exactly when P is greater than Q as unsigned numbers. Otherwise `gt_out` is 0 and `lt_out` is 1.
- R2: With `signed_mode` = 1, both words are read as two's complement with bit 7 as the sign. A negative word (bit 7 = 1) is less than any non-negative word.
- R3: `gt_out` and `lt_out` are never both 1 while the cascade inputs are not both 1. Equal words with both cascade inputs at 0 give both outputs 0.
- R4: While `p_load` = 1, the comparison uses the present value of `p_in` in the same cycle, with no clock edge needed.
- R5: While `p_load` = 0, the comparison uses the `p_in` value sampled at the last rising edge of `clk` at which `p_load` was 1 and `rst_n` was 1. Changes on `p_in` have no effect on the outputs.
- R6: A rising edge of `clk` with `rst_n` = 0 clears the stored P word to zero, whatever the value of `p_load`. With `p_load` = 0 afterwards, the comparison treats P as 0.
- R7: When the effective P equals `q_in`, `gt_out` equals `gt_cin` and `lt_out` equals `lt_cin`.
- R8: When the effective P differs from `q_in`, the cascade inputs have no effect on the outputs.
- R9: Two stages chained low-to-high form a 16-bit compare. The high stage can be in either mode and the low stage is unsigned with its cascade inputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the P word |
| rst_n | input | 1 | Synchronous active-low reset, clears the stored P word |
| p_in | input | 8 | P operand |
| q_in | input | 8 | Q operand |
| p_load | input | 1 | 1: P follows `p_in`; 0: P held from the last load |
| signed_mode | input | 1 | 0: unsigned compare; 1: two's-complement compare |
| gt_cin | input | 1 | Greater decision from the less-significant stage |
| lt_cin | input | 1 | Less decision from the less-significant stage |
| gt_out | output | 1 | P greater than Q |
| lt_out | output | 1 | P less than Q |

## Verification
The assertions assume that the cascade inputs are never both high. A real lower stage cannot drive that pair, and it would make the exclusivity property meaningless. They also assume that P, Q and the mode are stable across each sampling edge. The random stimulus therefore draws the cascade pair only from the three legal codes, and it changes every input on the falling edge. It forces Q to equal the effective P in a fair share of vectors, so that the pass-through path is exercised often and not only by chance.

// File: rtl/cmp_pkg.sv
// Package cmp_pkg: shared types for the magnitude comparator.
// Assumes: the decision pair is encoded gt/lt, both low meaning equal.
package cmp_pkg;
    typedef struct packed {
        logic gt;
        logic lt;
    } cmp_dec_t;
endpackage

// File: rtl/p_hold.sv
// p_hold: P operand storage. It is transparent while load is high and
// keeps the word sampled at the last loading clock edge while load is low.
// Assumes: the synchronous active-low reset stands in for power-up clear.
module p_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] held;

    // Record the operand on each loading edge; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (load)
            held <= d;
    end

    // Pass the live operand while loading, the record otherwise.
    always_comb begin
        q = load ? d : held;
    end
endmodule

// File: rtl/mag_core.sv
// mag_core: local magnitude decision on two words, MSB-first priority.
// Assumes: signed_mode selects two's complement by inverting the sign bit
// of both words, which turns a signed order into an unsigned one.
module mag_core
    import cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             signed_mode,
    output cmp_dec_t         dec,
    output logic             equal
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] ka, kb;
    logic [WIDTH:0]   eq_above;
    logic [WIDTH-1:0] gt_bit, lt_bit;

    // Build order keys: flip sign bits in signed mode.
    always_comb begin
        ka = a;
        kb = b;
        ka[MSB] = a[MSB] ^ signed_mode;
        kb[MSB] = b[MSB] ^ signed_mode;
    end

    assign eq_above[WIDTH] = 1'b1;

    // Per bit: decide here if every higher bit matched.
    for (genvar i = MSB; i >= 0; i--) begin : g_bit
        assign gt_bit[i]   = eq_above[i+1] & ka[i] & ~kb[i];
        assign lt_bit[i]   = eq_above[i+1] & ~ka[i] & kb[i];
        assign eq_above[i] = eq_above[i+1] & ~(ka[i] ^ kb[i]);
    end

    // Collapse the per-bit decisions.
    always_comb begin
        dec.gt = |gt_bit;
        dec.lt = |lt_bit;
        equal  = eq_above[0];
    end
endmodule

// File: rtl/cascade_merge.sv
// cascade_merge: chooses between the local decision and the decision of
// the less-significant stage. Assumes: equal flags an exact local match.
module cascade_merge
    import cmp_pkg::*;
(
    input  cmp_dec_t local_dec,
    input  logic     local_equal,
    input  cmp_dec_t chain_dec,
    output cmp_dec_t out_dec
);
    // A local match defers to the lower stage; otherwise the local decision wins.
    always_comb begin
        out_dec = local_equal ? chain_dec : local_dec;
    end
endmodule

// File: rtl/cmp_stage.sv
// cmp_stage: one cascadable comparator stage with a stored P operand.
// Assumes: the cascade inputs come from a lower stage (never both high);
// the lowest stage ties them low and only the top stage uses signed mode.
module cmp_stage
    import cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] p_in,
    input  logic [WIDTH-1:0] q_in,
    input  logic             p_load,
    input  logic             signed_mode,
    input  logic             gt_cin,
    input  logic             lt_cin,
    output logic             gt_out,
    output logic             lt_out
);
    logic [WIDTH-1:0] p_eff;
    cmp_dec_t         loc_dec, chain_dec, fin_dec;
    logic             loc_eq;

    p_hold #(.WIDTH(WIDTH)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (p_load),
        .d     (p_in),
        .q     (p_eff)
    );

    mag_core #(.WIDTH(WIDTH)) u_core (
        .a           (p_eff),
        .b           (q_in),
        .signed_mode (signed_mode),
        .dec         (loc_dec),
        .equal       (loc_eq)
    );

    // Pack the cascade inputs into a decision.
    always_comb begin
        chain_dec.gt = gt_cin;
        chain_dec.lt = lt_cin;
    end

    cascade_merge u_merge (
        .local_dec   (loc_dec),
        .local_equal (loc_eq),
        .chain_dec   (chain_dec),
        .out_dec     (fin_dec)
    );

    // Drive the decision ports.
    always_comb begin
        gt_out = fin_dec.gt;
        lt_out = fin_dec.lt;
    end
endmodule

// File: rtl/cmp_stage_chk.sv
// cmp_stage_chk: property checker for cmp_stage, attached by bind.
// Assumes: cascade inputs never both high (a real lower stage cannot drive that).
module cmp_stage_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] p_in,
    input logic [WIDTH-1:0] q_in,
    input logic             p_load,
    input logic             gt_cin,
    input logic             lt_cin,
    input logic             gt_out,
    input logic             lt_out,
    input logic [WIDTH-1:0] p_eff
);
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gt_cin && lt_cin) |-> !(gt_out && lt_out)); // R3

    AST_LIVE_P: assert property (@(posedge clk) disable iff (!rst_n)
        p_load |-> (p_eff == p_in)); // R4

    AST_HOLD_P: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_load && $past(!p_load) && $past(rst_n)) |-> $stable(p_eff)); // R5

    AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !p_load) |-> (p_eff == '0)); // R6

    AST_EQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (p_eff == q_in) |-> (gt_out == gt_cin && lt_out == lt_cin)); // R7

    AST_DIFF_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (p_eff != q_in) |-> (gt_out != lt_out)); // R8
endmodule

bind cmp_stage cmp_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .p_in   (p_in),
    .q_in   (q_in),
    .p_load (p_load),
    .gt_cin (gt_cin),
    .lt_cin (lt_cin),
    .gt_out (gt_out),
    .lt_out (lt_out),
    .p_eff  (p_eff)
);

// File: tb/sim_cmp_stage.sv
module sim_cmp_stage;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] p_in = '0, q_in = '0, lo_p = '0, lo_q = '0;
    logic p_load = 1'b0, signed_mode = 1'b0, gt_drv = 1'b0, lt_drv = 1'b0;
    logic chain = 1'b0;
    logic gt_out, lt_out, lo_gt, lo_lt, gt_cin, lt_cin;
    logic [7:0] model_hold = '0;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    assign gt_cin = chain ? lo_gt : gt_drv;
    assign lt_cin = chain ? lo_lt : lt_drv;

    cmp_stage u0 (.clk(clk), .rst_n(rst_n), .p_in(p_in), .q_in(q_in),
        .p_load(p_load), .signed_mode(signed_mode), .gt_cin(gt_cin),
        .lt_cin(lt_cin), .gt_out(gt_out), .lt_out(lt_out));

    cmp_stage u1 (.clk(clk), .rst_n(rst_n), .p_in(lo_p), .q_in(lo_q),
        .p_load(1'b1), .signed_mode(1'b0), .gt_cin(1'b0), .lt_cin(1'b0),
        .gt_out(lo_gt), .lt_out(lo_lt));

    // Reference decision from the requirements: returns {gt, lt}.
    function automatic logic [1:0] ref_cmp(input logic [7:0] a, input logic [7:0] b,
                                           input logic sgn, input logic gi, input logic li);
        if (a == b) return {gi, li};
        if (sgn) return ($signed(a) > $signed(b)) ? 2'b10 : 2'b01;
        return (a > b) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [7:0] eff_p();
        return p_load ? p_in : model_hold;
    endfunction

    task automatic check(input string tag, input logic [1:0] exp);
        n_chk++;
        if ({gt_out, lt_out} !== exp) begin
            n_bad++;
            $display("FAIL %s: got gt/lt=%b expected %b (p=%h q=%h load=%b sgn=%b cin=%b%b)",
                     tag, {gt_out, lt_out}, exp, p_in, q_in, p_load, signed_mode, gt_cin, lt_cin);
        end
    endtask

    // One clock edge, then update the bench's own record of the stored P.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) model_hold = '0;
        else if (p_load) model_hold = p_in;
        @(negedge clk);
    endtask

    task automatic chk_local(input string dflt);
        logic [7:0] a;
        a = eff_p();
        #2;
        check((a == q_in) ? "R7" : (signed_mode ? "R2" : dflt),
              ref_cmp(a, q_in, signed_mode, gt_drv, lt_drv));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        tick(); tick();
        // R6: after reset, a held P reads as zero.
        p_load = 0; q_in = 8'h00; #2;
        check("R6 reset equal", 2'b00);
        q_in = 8'h01; #1; check("R6 reset lt", 2'b01);
        rst_n = 1; tick();
        // R1 directed
        p_load = 1; p_in = 8'h80; q_in = 8'h7F; #2; check("R1 unsigned", 2'b10);
        // R2 directed: sign dominates
        signed_mode = 1; #1; check("R2 negative", 2'b01);
        p_in = 8'hFF; q_in = 8'h80; #1; check("R2 both negative", 2'b10);
        // R4: transparent without a clock edge
        p_in = 8'h10; q_in = 8'h20; signed_mode = 0; #1; check("R4 live", 2'b01);
        p_in = 8'h30; #1; check("R4 live change", 2'b10);
        // R5: hold across p_in changes
        p_in = 8'h42; tick();
        p_load = 0; p_in = 8'h00; q_in = 8'h42; #2; check("R5 hold equal", 2'b00);
        p_in = 8'hFF; #1; check("R5 p_in ignored", 2'b00);
        tick(); check("R5 after edge", 2'b00);
        // R7 / R8 directed
        gt_drv = 1; #1; check("R7 pass gt", 2'b10);
        gt_drv = 0; lt_drv = 1; #1; check("R7 pass lt", 2'b01);
        q_in = 8'h41; #1; check("R8 cin ignored", 2'b10);
        lt_drv = 0; gt_drv = 1; q_in = 8'h43; #1; check("R8 cin ignored", 2'b01);
        gt_drv = 0;
        // R6: reset clears even while loading path is held
        rst_n = 0; p_load = 1; p_in = 8'h99; tick();
        rst_n = 1; p_load = 0; q_in = 8'h00; #2; check("R6 clear with load", 2'b00);
        // R3: equal words, cascade low
        p_load = 1; p_in = 8'h5A; q_in = 8'h5A; #1; check("R3 equal both low", 2'b00);
        tick();

        // Random local vectors.
        for (int i = 0; i < 3000; i++) begin
            int c;
            if ($urandom_range(99) < 2) rst_n = 0; else rst_n = 1;
            p_load = ($urandom_range(3) != 0);
            signed_mode = $urandom_range(1);
            p_in = 8'($urandom);
            c = $urandom_range(2);
            gt_drv = (c == 1); lt_drv = (c == 2);
            if ($urandom_range(3) == 0) q_in = eff_p();
            else if ($urandom_range(7) == 0) q_in = eff_p() ^ 8'h80;
            else q_in = 8'($urandom);
            chk_local("R1");
            tick();
        end

        // R9: 16-bit compares through two chained stages.
        rst_n = 1; chain = 1; p_load = 1; gt_drv = 0; lt_drv = 0;
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] a, b;
            a = 16'($urandom); b = 16'($urandom);
            if (i % 4 == 0) b = {a[15:8], b[7:0]};
            if (i % 8 == 0) b = a;
            signed_mode = $urandom_range(1);
            p_in = a[15:8]; q_in = b[15:8]; lo_p = a[7:0]; lo_q = b[7:0];
            #2;
            if (a == b) check("R9 chain eq", 2'b00);
            else if (signed_mode) check("R9 chain signed", ($signed(a) > $signed(b)) ? 2'b10 : 2'b01);
            else check("R9 chain unsigned", (a > b) ? 2'b10 : 2'b01);
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule